// File: doc/BRIEF.md
# UART FIFO DMA Request Generator

This block drives the receive and transmit DMA request lines of a UART whose receive and transmit FIFOs each hold 64 bytes. It works out which of four DMA modes is in force from two control paths: a single bit in the classic FIFO control field, and a separate extended control path with its own enable bit and a 2-bit mode field. In mode 0 both requests are held inactive. In modes 1 to 3 each direction runs its own burst handshake.

A request rises when its FIFO can take a full burst. For receive, the FIFO must hold at least the threshold. For transmit, the FIFO must have free room for at least the space count, which is always true when it is empty. While a request is raised, a burst counter counts the DMA's per-byte strobes. The request falls only when the whole burst has been moved. The burst size comes from a 2-bit auto field, or from a 4-bit trigger field joined with that auto field. With the FIFOs disabled, every burst is one character.

Top module: `uart_dma_req`

## Requirements
- R1: When extEn is 0, dmaMode equals {0, fcrDma}: mode 0 or mode 1.
- R2: When extEn is 1, dmaMode equals extMode and fcrDma has no effect on it.
- R3: While dmaMode is 0, rxReq and txReq are low from the next clock edge on. Entering mode 0 in the middle of a burst abandons that burst. After reset, both requests are low.
- R4: With the FIFOs enabled and the receiver idle, rxReq rises at the clock edge where rxLevel is at least the receive burst size.
- R5: Once raised, rxReq stays high until the edge of the Nth dmaRdStb cycle, where N is the receive burst size. It drops at that edge. Fewer reads leave it high, whatever rxLevel does.
- R6: With the transmitter idle, an empty transmit FIFO (txLevel 0) raises txReq at the next edge.
- R7: Once raised, txReq stays high until the edge of the Nth dmaWrStb cycle, where N is the transmit burst size. It drops at that edge. Fewer writes leave it high.
- R8: With the FIFOs enabled and the transmitter idle, txReq rises when 64 minus txLevel is at least the transmit burst size. Less free room keeps it low.
- R9: The burst size comes from the trig and auto fields. If trig is nonzero, the size is trig*4+auto, so trig=14 with auto=0 gives 56. If trig is zero, auto 0/1/2/3 gives 8/16/32/56.
- R10: With fifoEn at 0, the burst size is 1. rxReq rises when rxLevel is nonzero. txReq rises when txLevel is 0. Each request drops after one strobe.
- R11: A strobe that arrives while its request is low does not count toward the next burst.
- R12: If a request drops while its rise condition still holds, it is low for exactly one cycle and then rises again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fifoEn | input | 1 | FIFOs enabled; 0 selects single-character transfers |
| fcrDma | input | 1 | DMA mode bit of the classic FIFO control field |
| extEn | input | 1 | Selects the extended mode path |
| extMode | input | 2 | Extended DMA mode, 0 to 3 |
| rxTrig | input | 4 | Receive trigger field, upper part of the burst size |
| rxAuto | input | 2 | Receive auto-size field |
| txTrig | input | 4 | Transmit trigger field, upper part of the burst size |
| txAuto | input | 2 | Transmit auto-size field |
| rxLevel | input | 7 | Bytes held in the receive FIFO |
| txLevel | input | 7 | Bytes held in the transmit FIFO |
| dmaRdStb | input | 1 | One receive byte read by the DMA this cycle |
| dmaWrStb | input | 1 | One transmit byte written by the DMA this cycle |
| rxReq | output | 1 | Receive DMA request |
| txReq | output | 1 | Transmit DMA request |
| dmaMode | output | 2 | Decoded DMA mode |

## Verification
Two events can land on the same clock edge: the strobe that ends a burst, and a FIFO level that still meets the rise condition. The bench sets this up in both directions at once. It holds rxLevel above the threshold and txLevel at 0 while it issues eight reads and eight writes in the same cycles. Each request must then be low for exactly one cycle and high again on the next, as R12 requires. A behavioural reference model is compared with the design on every clock; it ends bursts by counting strobes and re-evaluates levels only while a direction is idle.

// File: rtl/uart_dma_pkg.sv
package uart_dma_pkg;

  // Handshake strobes from control to datapath; index 0 = receive, 1 = transmit.
  typedef struct packed {
    logic [1:0] load;
    logic [1:0] dec;
    logic [1:0] clr;
  } dmaStb_t;

  // Burst size from the trigger and auto fields.
  function automatic int unsigned burstSize(input logic [3:0] trig,
                                            input logic [1:0] autoSel,
                                            input logic       fen);
    if (!fen) return 1;
    if (trig != 4'd0) return 32'({trig, autoSel});
    case (autoSel)
      2'd0:    return 8;
      2'd1:    return 16;
      2'd2:    return 32;
      default: return 56;
    endcase
  endfunction

endpackage

// File: rtl/uart_dma_cnt.sv
module uart_dma_cnt #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          load,
  input  logic          dec,
  input  logic          clr,
  input  logic [CW-1:0] loadVal,
  output logic          last
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN)                  cnt <= '0;
    else if (clr)               cnt <= '0;
    else if (load)              cnt <= loadVal;
    else if (dec && cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign last = (cnt == CW'(1));
endmodule

// File: rtl/uart_dma_dp.sv
module uart_dma_dp
  import uart_dma_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  dmaStb_t          stb,
  input  logic             fifoEn,
  input  logic             fcrDma,
  input  logic             extEn,
  input  logic [1:0]       extMode,
  input  logic [3:0]       rxTrig,
  input  logic [1:0]       rxAuto,
  input  logic [3:0]       txTrig,
  input  logic [1:0]       txAuto,
  input  logic [LVL_W-1:0] rxLevel,
  input  logic [LVL_W-1:0] txLevel,
  output logic [1:0]       dmaMode,
  output logic             modeOn,
  output logic [1:0]       qual,
  output logic [1:0]       last
);
  logic [LVL_W-1:0] size [2];
  logic [LVL_W:0]   txRoom;

  assign dmaMode = extEn ? extMode : {1'b0, fcrDma};
  assign modeOn  = (dmaMode != 2'd0);

  assign size[0] = LVL_W'(burstSize(rxTrig, rxAuto, fifoEn));
  assign size[1] = LVL_W'(burstSize(txTrig, txAuto, fifoEn));

  assign txRoom  = (LVL_W+1)'(DEPTH) - {1'b0, txLevel};

  assign qual[0] = fifoEn ? (rxLevel >= size[0]) : (rxLevel != '0);
  assign qual[1] = fifoEn ? (txRoom >= {1'b0, size[1]}) : (txLevel == '0);

  for (genvar ch = 0; ch < 2; ch++) begin : g_cnt
    uart_dma_cnt #(.CW(LVL_W)) cnt_i (
      .clk     (clk),
      .rstN    (rstN),
      .load    (stb.load[ch]),
      .dec     (stb.dec[ch]),
      .clr     (stb.clr[ch]),
      .loadVal (size[ch]),
      .last    (last[ch])
    );
  end
endmodule

// File: rtl/uart_dma_ctl.sv
module uart_dma_ctl
  import uart_dma_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       modeOn,
  input  logic [1:0] qual,
  input  logic [1:0] last,
  input  logic       dmaRdStb,
  input  logic       dmaWrStb,
  output dmaStb_t    stb,
  output logic       rxReq,
  output logic       txReq
);
  logic [1:0] act;
  logic [1:0] xfer;
  logic [1:0] loadV, decV, clrV;

  assign xfer = {dmaWrStb, dmaRdStb};

  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    assign clrV[ch]  = !modeOn;
    assign loadV[ch] = modeOn && !act[ch] && qual[ch];
    assign decV[ch]  = modeOn && act[ch] && xfer[ch];

    always_ff @(posedge clk) begin
      if (!rstN)                      act[ch] <= 1'b0;
      else if (clrV[ch])              act[ch] <= 1'b0;
      else if (loadV[ch])             act[ch] <= 1'b1;
      else if (decV[ch] && last[ch])  act[ch] <= 1'b0;
    end
  end

  assign stb   = '{load: loadV, dec: decV, clr: clrV};
  assign rxReq = act[0];
  assign txReq = act[1];
endmodule

// File: rtl/uart_dma_req.sv
module uart_dma_req
  import uart_dma_pkg::*;
#(
  parameter  int DEPTH = 64,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fifoEn,
  input  logic             fcrDma,
  input  logic             extEn,
  input  logic [1:0]       extMode,
  input  logic [3:0]       rxTrig,
  input  logic [1:0]       rxAuto,
  input  logic [3:0]       txTrig,
  input  logic [1:0]       txAuto,
  input  logic [LVL_W-1:0] rxLevel,
  input  logic [LVL_W-1:0] txLevel,
  input  logic             dmaRdStb,
  input  logic             dmaWrStb,
  output logic             rxReq,
  output logic             txReq,
  output logic [1:0]       dmaMode
);
  dmaStb_t    stb;
  logic       modeOn;
  logic [1:0] qual, last;

  uart_dma_dp #(.DEPTH(DEPTH), .LVL_W(LVL_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .fifoEn(fifoEn), .fcrDma(fcrDma),
    .extEn(extEn), .extMode(extMode), .rxTrig(rxTrig), .rxAuto(rxAuto),
    .txTrig(txTrig), .txAuto(txAuto), .rxLevel(rxLevel), .txLevel(txLevel),
    .dmaMode(dmaMode), .modeOn(modeOn), .qual(qual), .last(last)
  );

  uart_dma_ctl ctl_i (
    .clk(clk), .rstN(rstN), .modeOn(modeOn), .qual(qual), .last(last),
    .dmaRdStb(dmaRdStb), .dmaWrStb(dmaWrStb), .stb(stb),
    .rxReq(rxReq), .txReq(txReq)
  );
endmodule

// File: rtl/uart_dma_req_chk.sv
module uart_dma_req_chk #(
  parameter  int DEPTH = 64,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             fifoEn,
  input logic             fcrDma,
  input logic             extEn,
  input logic [1:0]       extMode,
  input logic [3:0]       rxTrig,
  input logic [1:0]       rxAuto,
  input logic [3:0]       txTrig,
  input logic [1:0]       txAuto,
  input logic [LVL_W-1:0] rxLevel,
  input logic [LVL_W-1:0] txLevel,
  input logic             dmaRdStb,
  input logic             dmaWrStb,
  input logic             rxReq,
  input logic             txReq,
  input logic [1:0]       dmaMode
);
  p_mode0_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    (dmaMode == 2'd0) |=> (!rxReq && !txReq));

  p_rx_rise_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxReq) |-> ($past(rxLevel) != '0 && $past(dmaMode) != 2'd0));

  p_rx_fall_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(rxReq) && $past(dmaMode) != 2'd0) |-> $past(dmaRdStb));

  p_rx_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rxReq && !dmaRdStb && dmaMode != 2'd0) |=> rxReq);

  p_tx_fall_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(txReq) && $past(dmaMode) != 2'd0) |-> $past(dmaWrStb));

  p_tx_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (txReq && !dmaWrStb && dmaMode != 2'd0) |=> txReq);

  p_tx_rise_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txReq) |-> ($past(txLevel) < LVL_W'(DEPTH)));
endmodule

bind uart_dma_req uart_dma_req_chk #(.DEPTH(DEPTH)) chk_i (.*);

// File: tb/uart_dma_req_tb_top.sv
`timescale 1ns/1ps
module uart_dma_req_tb_top;
  localparam int DEPTH = 64;
  localparam int LVL_W = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fifoEn = 1'b1, fcrDma = 1'b0, extEn = 1'b0;
  logic [1:0] extMode = 2'd0, rxAuto = 2'd0, txAuto = 2'd0;
  logic [3:0] rxTrig = 4'd0, txTrig = 4'd0;
  logic [LVL_W-1:0] rxLevel = '0, txLevel = 7'd64;
  logic dmaRdStb = 1'b0, dmaWrStb = 1'b0;
  logic rxReq, txReq;
  logic [1:0] dmaMode;

  int checks = 0, errors = 0;
  string phase = "R3";

  always #2 clk = ~clk;

  uart_dma_req #(.DEPTH(DEPTH)) dut_i (.*);

  // Reference model
  int mAct [2];
  int mCnt [2];

  function automatic int refMode();
    return extEn ? int'(extMode) : int'(fcrDma);
  endfunction

  function automatic int refSize(int trig, int au);
    if (!fifoEn) return 1;
    if (trig != 0) return trig * 4 + au;
    return (au == 0) ? 8 : (au == 1) ? 16 : (au == 2) ? 32 : 56;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mAct[0] = 0; mAct[1] = 0; mCnt[0] = 0; mCnt[1] = 0;
    end else if (refMode() == 0) begin
      mAct[0] = 0; mAct[1] = 0;
    end else begin
      for (int d = 0; d < 2; d++) begin
        int sz;
        bit q, s;
        sz = (d == 0) ? refSize(rxTrig, rxAuto) : refSize(txTrig, txAuto);
        if (d == 0) begin
          q = fifoEn ? (int'(rxLevel) >= sz) : (rxLevel != 0);
          s = dmaRdStb;
        end else begin
          q = fifoEn ? (DEPTH - int'(txLevel) >= sz) : (txLevel == 0);
          s = dmaWrStb;
        end
        if (mAct[d] == 0) begin
          if (q) begin mAct[d] = 1; mCnt[d] = sz; end
        end else if (s) begin
          mCnt[d]--;
          if (mCnt[d] == 0) mAct[d] = 0;
        end
      end
    end
  end

  always @(posedge clk) begin
    #1;
    if (rstN) begin
      checks++;
      if (rxReq !== (mAct[0] != 0) || txReq !== (mAct[1] != 0) ||
          dmaMode !== 2'(refMode())) begin
        errors++;
        $display("FAIL %s cycle compare: rx/tx/mode act=%b/%b/%0d exp=%0d/%0d/%0d",
                 phase, rxReq, txReq, dmaMode, mAct[0], mAct[1], refMode());
      end
    end
  end

  task automatic chk(string req, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic toPost(); @(posedge clk); #1; endtask
  task automatic toNeg();  @(negedge clk); endtask

  task automatic rdBurst(int n);
    toNeg(); dmaRdStb = 1'b1;
    repeat (n) toNeg();
    dmaRdStb = 1'b0;
  endtask

  task automatic wrBurst(int n);
    toNeg(); dmaWrStb = 1'b1;
    repeat (n) toNeg();
    dmaWrStb = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired in %s", phase);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) toNeg();
    rstN = 1'b1;
    toPost();
    chk("R3 reset rxReq", 2'(rxReq), 0);
    chk("R3 reset txReq", 2'(txReq), 0);

    // Mode decode
    phase = "R1";
    toNeg(); fcrDma = 1'b1; #0.5;
    chk("R1 legacy mode", dmaMode, 2'd1);
    phase = "R2";
    toNeg(); extEn = 1'b1; extMode = 2'd3; fcrDma = 1'b0; #0.5;
    chk("R2 ext mode 3", dmaMode, 2'd3);
    toNeg(); extMode = 2'd0; fcrDma = 1'b1; #0.5;
    chk("R2 legacy bit ignored", dmaMode, 2'd0);
    toNeg(); extMode = 2'd2; #0.5;
    chk("R2 ext mode 2", dmaMode, 2'd2);

    // Mode 0 keeps requests low
    phase = "R3";
    toNeg(); extMode = 2'd0; rxLevel = 7'd40; txLevel = 7'd0;
    repeat (3) toPost();
    chk("R3 mode0 rx low", 2'(rxReq), 0);
    chk("R3 mode0 tx low", 2'(txReq), 0);
    toNeg(); extEn = 1'b0; fcrDma = 1'b1; rxLevel = 7'd7; txLevel = 7'd64;
    repeat (3) toPost();

    // Idle strobes ignored, then rx threshold 8
    phase = "R11";
    rdBurst(3);
    phase = "R4";
    toPost();
    chk("R4 below threshold", 2'(rxReq), 0);
    toNeg(); rxLevel = 7'd8;
    toPost();
    chk("R4 rises at threshold", 2'(rxReq), 1);
    phase = "R5";
    rdBurst(7);
    toPost();
    chk("R11/R5 partial reads keep rxReq", 2'(rxReq), 1);
    toNeg(); rxLevel = 7'd1; dmaRdStb = 1'b1;
    toPost();
    chk("R5 drops after burst", 2'(rxReq), 0);
    toNeg(); dmaRdStb = 1'b0;
    repeat (2) toPost();
    chk("R5 stays low", 2'(rxReq), 0);

    // Burst size forms
    phase = "R9";
    toNeg(); rxTrig = 4'd14; rxAuto = 2'd0; rxLevel = 7'd55;
    repeat (2) toPost();
    chk("R9 trig14 below 56", 2'(rxReq), 0);
    toNeg(); rxLevel = 7'd56;
    toPost();
    chk("R9 trig14 at 56", 2'(rxReq), 1);
    toNeg(); rxLevel = 7'd0;
    rdBurst(55);
    toPost();
    chk("R9 55 of 56 keep", 2'(rxReq), 1);
    rdBurst(1);
    toPost();
    chk("R9 56 reads drop", 2'(rxReq), 0);
    toNeg(); rxTrig = 4'd0; rxAuto = 2'd1; rxLevel = 7'd15;
    repeat (2) toPost();
    chk("R9 auto1 below 16", 2'(rxReq), 0);
    toNeg(); rxLevel = 7'd16;
    toPost();
    chk("R9 auto1 at 16", 2'(rxReq), 1);
    toNeg(); rxLevel = 7'd0;
    rdBurst(16);
    toNeg(); rxTrig = 4'd1; rxAuto = 2'd2; rxLevel = 7'd6;
    toPost(); toPost();
    chk("R9 trig1 auto2 = 6", 2'(rxReq), 1);
    toNeg(); rxLevel = 7'd0;
    rdBurst(6);
    toPost();
    chk("R9 6 reads drop", 2'(rxReq), 0);

    // Transmit
    phase = "R6";
    toNeg(); txTrig = 4'd0; txAuto = 2'd0; txLevel = 7'd0;
    toPost();
    chk("R6 empty raises txReq", 2'(txReq), 1);
    phase = "R7";
    wrBurst(3);
    toPost();
    chk("R7 short write keeps txReq", 2'(txReq), 1);
    toNeg(); txLevel = 7'd60;
    wrBurst(5);
    toPost();
    chk("R7 drops after 8 writes", 2'(txReq), 0);
    phase = "R8";
    repeat (2) toPost();
    chk("R8 room 4 stays low", 2'(txReq), 0);
    toNeg(); txLevel = 7'd56;
    toPost();
    chk("R8 room 8 raises", 2'(txReq), 1);

    // Coincident burst ends in both directions
    phase = "R12";
    toNeg(); rxAuto = 2'd0; rxTrig = 4'd0; rxLevel = 7'd20; txLevel = 7'd0;
    toPost(); toPost();
    chk("R12 rx up", 2'(rxReq), 1);
    toNeg(); dmaRdStb = 1'b1; dmaWrStb = 1'b1;
    repeat (7) toNeg();
    toPost();
    chk("R12 rx one low cycle", 2'(rxReq), 0);
    chk("R12 tx one low cycle", 2'(txReq), 0);
    toNeg(); dmaRdStb = 1'b0; dmaWrStb = 1'b0;
    toPost();
    chk("R12 rx back up", 2'(rxReq), 1);
    chk("R12 tx back up", 2'(txReq), 1);

    // Mode 0 abandons a burst
    phase = "R3";
    rdBurst(2);
    toNeg(); extEn = 1'b1; extMode = 2'd0;
    toPost();
    chk("R3 mid-burst rx cleared", 2'(rxReq), 0);
    chk("R3 mid-burst tx cleared", 2'(txReq), 0);
    toNeg(); extMode = 2'd1; rxLevel = 7'd0; txLevel = 7'd64;
    repeat (2) toPost();

    // FIFOs disabled: single characters
    phase = "R10";
    toNeg(); fifoEn = 1'b0; rxLevel = 7'd1;
    toPost();
    chk("R10 rx one char", 2'(rxReq), 1);
    toNeg(); rxLevel = 7'd0; dmaRdStb = 1'b1;
    toPost();
    chk("R10 rx drops after one", 2'(rxReq), 0);
    toNeg(); dmaRdStb = 1'b0; txLevel = 7'd1;
    repeat (2) toPost();
    chk("R10 tx holding full", 2'(txReq), 0);
    toNeg(); txLevel = 7'd0;
    toPost();
    chk("R10 tx empty raises", 2'(txReq), 1);
    toNeg(); txLevel = 7'd1; dmaWrStb = 1'b1;
    toPost();
    chk("R10 tx drops after one", 2'(txReq), 0);
    toNeg(); dmaWrStb = 1'b0;
    repeat (3) toPost();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule